// File: doc/BRIEF.md
# Subtractor-Based Magnitude Comparator with Overflow Flags

This combinational unit runs two operands of a fixed parameter width through one carry chain. In subtract mode the second operand is inverted and the carry into the lowest bit is forced to one, so the chain produces the difference. In add mode both operands pass straight through and the carry-in is zero.

Every evaluation reports two overflow flags. The first flag treats the operands as unsigned numbers. The second treats them as two's complement numbers.

In subtract mode the block also returns three relation outputs: less, equal and greater. These come from the same carries rather than from a separate magnitude compare. An interpretation input chooses whether the relation is signed or unsigned. In signed mode the sign of the difference is corrected when the subtraction overflows. Typical use is as the compare and overflow stage of a small datapath, next to an accumulator or a branch unit.

Top module: `cmp_sub_top`

## Requirements
- R1: With op_sub_i=1, diff_o equals (a_i - b_i) modulo 2^WIDTH. With op_sub_i=0, diff_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With op_sub_i=0, uovf_o is 1 exactly when a_i + b_i, taken as unsigned numbers, exceeds 2^WIDTH - 1. This is a final carry-out of 1.
- R3: With op_sub_i=1, uovf_o is 1 exactly when unsigned a_i is smaller than unsigned b_i. This is a final carry-out of 0.
- R4: sovf_o is 1 exactly when the two's complement sum or difference falls outside -2^(WIDTH-1) to 2^(WIDTH-1)-1. With the default width of 4, that range is -8 to +7. This holds in both add and subtract mode.
- R5: With op_sub_i=1, eq_o is 1 exactly when every bit of the difference is zero, that is, when a_i equals b_i.
- R6: With op_sub_i=1 and is_signed_i=0, lt_o is 1 exactly when unsigned a_i < unsigned b_i.
- R7: With op_sub_i=1 and is_signed_i=1, lt_o is 1 exactly when signed a_i < signed b_i. This must hold even when the difference overflows, so that the raw sign bit is wrong.
- R8: With op_sub_i=1, gt_o is 1 exactly when neither lt_o nor eq_o is 1. Exactly one of the three relation outputs is 1.
- R9: With op_sub_i=0, lt_o, eq_o and gt_o are all 0.
- R10: uovf_o and sovf_o do not depend on is_signed_i. Both flags are reported for either interpretation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| op_sub_i | input | 1 | 1 = subtract and compare, 0 = add |
| is_signed_i | input | 1 | 1 = relation uses two's complement, 0 = unsigned |
| diff_o | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| uovf_o | output | 1 | Unsigned overflow of the current operation |
| sovf_o | output | 1 | Two's complement overflow of the current operation |
| lt_o | output | 1 | a_i below b_i (subtract mode only) |
| eq_o | output | 1 | a_i equal to b_i (subtract mode only) |
| gt_o | output | 1 | a_i above b_i (subtract mode only) |

## Verification
The hardest case is a signed compare whose subtraction overflows. Here the raw sign bit points the wrong way, and only operands of opposite sign with a large enough gap reach it. Random operands hit it only now and then. Directed vectors therefore pair the most negative value against positive values and the most positive value against negative values, in signed mode, and check the relation and both flags. The same vectors are replayed in unsigned mode to show that the flags do not move.

// File: rtl/cmp_sub_pkg.sv
`timescale 1ns/1ps
// Shared types for the subtract/compare unit.
package cmp_sub_pkg;
    // Operation carried on the shared carry chain.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_kind_e;
endpackage

// File: rtl/cmp_sub_opnd.sv
`timescale 1ns/1ps
// Operand conditioning. It feeds either B or its one's complement to the chain.
// In subtract mode it also sets the carry-in, which completes two's complement negation.
// Assumes: WIDTH >= 2.
module cmp_sub_opnd
    import cmp_sub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] b_i,
    input  op_kind_e         op_i,
    output logic [WIDTH-1:0] b_eff_o,
    output logic             cin_o
);
    // Select B or ~B and the matching carry-in.
    always_comb begin
        b_eff_o = (op_i == OP_SUB) ? ~b_i : b_i;
        cin_o   = (op_i == OP_SUB);
    end
endmodule

// File: rtl/cmp_sub_chain.sv
`timescale 1ns/1ps
// Carry chain built from per-bit generate/propagate terms.
// It returns the sum, the carry into the top bit and the final carry-out.
// Assumes: WIDTH >= 2.
module cmp_sub_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_top_in_o,
    output logic             c_out_o
);
    logic [WIDTH-1:0] gen_w;
    logic [WIDTH-1:0] prop_w;

    // Per-bit generate and propagate terms.
    for (genvar k = 0; k < WIDTH; k++) begin : g_pg
        assign gen_w[k]  = x_i[k] & y_i[k];
        assign prop_w[k] = x_i[k] ^ y_i[k];
    end

    // Walk the carries from bit 0 upward and form the sum bits.
    always_comb begin
        logic [WIDTH:0] cy;
        cy[0] = cin_i;
        for (int k = 0; k < WIDTH; k++) begin
            cy[k+1]  = gen_w[k] | (prop_w[k] & cy[k]);
            sum_o[k] = prop_w[k] ^ cy[k];
        end
        c_top_in_o = cy[WIDTH-1];
        c_out_o    = cy[WIDTH];
    end
endmodule

// File: rtl/cmp_sub_flags.sv
`timescale 1ns/1ps
// Overflow flags taken from the chain's top carries.
// Assumes: the carry-in was one for subtract and zero for add.
module cmp_sub_flags
    import cmp_sub_pkg::*;
(
    input  op_kind_e op_i,
    input  logic     c_top_in_i,
    input  logic     c_out_i,
    output logic     uovf_o,
    output logic     sovf_o
);
    // Unsigned test flips between add and subtract. Signed test compares the top two carries.
    always_comb begin
        uovf_o = (op_i == OP_SUB) ? ~c_out_i : c_out_i;
        sovf_o = c_top_in_i ^ c_out_i;
    end
endmodule

// File: rtl/cmp_sub_rel.sv
`timescale 1ns/1ps
// Relation decode from the difference. It is active only in subtract mode.
// Signed mode fixes the sign with the overflow flag. Unsigned mode uses the borrow.
// Assumes: WIDTH >= 2.
module cmp_sub_rel
    import cmp_sub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_kind_e         op_i,
    input  logic             is_signed_i,
    input  logic [WIDTH-1:0] diff_i,
    input  logic             c_out_i,
    input  logic             sovf_i,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o
);
    localparam int MSB = WIDTH - 1;

    logic zero_w;
    logic below_w;

    // Zero detect plus the corrected "negative" decision.
    always_comb begin
        zero_w  = ~|diff_i;
        below_w = is_signed_i ? (diff_i[MSB] ^ sovf_i) : ~c_out_i;
    end

    // Gate the three relations with the operation.
    always_comb begin
        if (op_i == OP_SUB) begin
            lt_o = below_w;
            eq_o = zero_w;
            gt_o = ~below_w & ~zero_w;
        end else begin
            lt_o = 1'b0;
            eq_o = 1'b0;
            gt_o = 1'b0;
        end
    end
endmodule

// File: rtl/cmp_sub_top.sv
`timescale 1ns/1ps
// Subtractor-based comparator with unsigned and signed overflow flags.
// It is purely combinational, with no state, so it needs no clock or reset.
// Assumes: WIDTH >= 2.
module cmp_sub_top
    import cmp_sub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             op_sub_i,
    input  logic             is_signed_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             uovf_o,
    output logic             sovf_o,
    output logic             lt_o,
    output logic             eq_o,
    output logic             gt_o
);
    op_kind_e         op_w;
    logic [WIDTH-1:0] b_eff_w;
    logic             cin_w;
    logic             c_top_w;
    logic             c_out_w;
    logic             sovf_w;

    // Map the control pin to the operation type.
    assign op_w = op_kind_e'(op_sub_i);

    cmp_sub_opnd #(.WIDTH(WIDTH)) u_opnd (
        .b_i     (b_i),
        .op_i    (op_w),
        .b_eff_o (b_eff_w),
        .cin_o   (cin_w)
    );

    cmp_sub_chain #(.WIDTH(WIDTH)) u_chain (
        .x_i        (a_i),
        .y_i        (b_eff_w),
        .cin_i      (cin_w),
        .sum_o      (diff_o),
        .c_top_in_o (c_top_w),
        .c_out_o    (c_out_w)
    );

    cmp_sub_flags u_flags (
        .op_i       (op_w),
        .c_top_in_i (c_top_w),
        .c_out_i    (c_out_w),
        .uovf_o     (uovf_o),
        .sovf_o     (sovf_w)
    );

    assign sovf_o = sovf_w;

    cmp_sub_rel #(.WIDTH(WIDTH)) u_rel (
        .op_i        (op_w),
        .is_signed_i (is_signed_i),
        .diff_i      (diff_o),
        .c_out_i     (c_out_w),
        .sovf_i      (sovf_w),
        .lt_o        (lt_o),
        .eq_o        (eq_o),
        .gt_o        (gt_o)
    );
endmodule

// File: rtl/cmp_sub_chk.sv
`timescale 1ns/1ps
// Checker for cmp_sub_top. Cross-checks the flags and relations at the ports.
// The block holds no state, so the checks are immediate and re-evaluated on every change.
module cmp_sub_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             op_sub_i,
    input logic             is_signed_i,
    input logic [WIDTH-1:0] diff_o,
    input logic             uovf_o,
    input logic             sovf_o,
    input logic             lt_o,
    input logic             eq_o,
    input logic             gt_o
);
    localparam int MSB = WIDTH - 1;

    // Port-level consistency checks.
    always_comb begin
        // R8
        sub_onehot_chk: assert (!op_sub_i || $onehot({lt_o, eq_o, gt_o}));
        // R9
        add_quiet_chk: assert (op_sub_i || ({lt_o, eq_o, gt_o} == 3'b000));
        // R5
        eq_zero_chk: assert (!eq_o || (a_i == b_i));
        // R3
        borrow_lt_chk: assert (!(op_sub_i && !is_signed_i) || (uovf_o == lt_o));
        // R4
        sov_sign_chk: assert (sovf_o == (((a_i[MSB] == (b_i[MSB] ^ op_sub_i))) && (diff_o[MSB] != a_i[MSB])));
    end
endmodule

bind cmp_sub_top cmp_sub_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i         (a_i),
    .b_i         (b_i),
    .op_sub_i    (op_sub_i),
    .is_signed_i (is_signed_i),
    .diff_o      (diff_o),
    .uovf_o      (uovf_o),
    .sovf_o      (sovf_o),
    .lt_o        (lt_o),
    .eq_o        (eq_o),
    .gt_o        (gt_o)
);

// File: tb/cmp_sub_top_tb_top.sv
`timescale 1ns/1ps
// Bench for cmp_sub_top. It mixes directed corners with seeded random operands.
// Expected values come from integer arithmetic in the bench functions.
module cmp_sub_top_tb_top;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;
    localparam int SMAX = (1 << (W - 1)) - 1;
    localparam int SMIN = -(1 << (W - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic         sub, sgn;
    logic [W-1:0] diff;
    logic         uovf, sovf, lt, eq, gt;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cmp_sub_top #(.WIDTH(W)) dut_i (
        .a_i(a), .b_i(b), .op_sub_i(sub), .is_signed_i(sgn),
        .diff_o(diff), .uovf_o(uovf), .sovf_o(sovf),
        .lt_o(lt), .eq_o(eq), .gt_o(gt)
    );

    // Convert a W-bit pattern to its two's complement value.
    function automatic int sv(input int x);
        return (x > SMAX) ? x - (1 << W) : x;
    endfunction

    // Record one comparison between actual and expected.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s a=%0d b=%0d sub=%0d sgn=%0d actual=%0d expected=%0d",
                     req, what, a, b, sub, sgn, act, exp);
        end
    endtask

    // Apply one vector, wait to mid-cycle and check every output.
    task automatic apply(input int av, input int bv, input bit s, input bit g);
        int ua, ub, sa, sb, sres, e_res, e_lt;
        bit e_uov, e_sov;
        @(posedge clk);
        a = W'(av); b = W'(bv); sub = s; sgn = g;
        @(negedge clk);
        ua = av & MASK; ub = bv & MASK; sa = sv(ua); sb = sv(ub);
        if (s) begin
            e_res = (ua - ub) & MASK;
            e_uov = (ua < ub);
            sres  = sa - sb;
        end else begin
            e_res = (ua + ub) & MASK;
            e_uov = ((ua + ub) > MASK);
            sres  = sa + sb;
        end
        e_sov = (sres > SMAX) || (sres < SMIN);
        chk("R1", "diff", int'(diff), e_res);
        chk(s ? "R3" : "R2", "uovf", int'(uovf), int'(e_uov));
        chk("R4", "sovf", int'(sovf), int'(e_sov));
        if (s) begin
            e_lt = g ? int'(sa < sb) : int'(ua < ub);
            chk("R5", "eq", int'(eq), int'(ua == ub));
            chk(g ? "R7" : "R6", "lt", int'(lt), e_lt);
            chk("R8", "gt", int'(gt), int'(!e_lt && ua != ub));
        end else begin
            chk("R9", "rel", int'({lt, eq, gt}), 0);
        end
    endtask

    // Main sequence: reset, directed corners, then random vectors.
    initial begin
        a = '0; b = '0; sub = 1'b1; sgn = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Idle state with zero operands in subtract mode: equal, no flags.
        chk("R5", "idle eq", int'(eq), 1);
        chk("R3", "idle uovf", int'(uovf), 0);
        chk("R1", "idle diff", int'(diff), 0);

        // Signed compares that overflow, run in both interpretations (R7, R10).
        for (int i = 0; i < 2; i++) begin
            apply(8, 1, 1'b1, i[0]);   // -8 - 1
            apply(8, 7, 1'b1, i[0]);   // -8 - 7
            apply(7, 8, 1'b1, i[0]);   // 7 - (-8)
            apply(6, 13, 1'b1, i[0]);  // 6 - (-3)
            apply(15, 0, 1'b1, i[0]);
            apply(0, 15, 1'b1, i[0]);
            apply(9, 9, 1'b1, i[0]);
        end
        // Addition corners (R2, R4, R9).
        apply(10, 7, 1'b0, 1'b0);
        apply(5, 6, 1'b0, 1'b1);
        apply(12, 9, 1'b0, 1'b0);
        apply(15, 1, 1'b0, 1'b1);
        apply(3, 2, 1'b0, 1'b0);
        apply(14, 10, 1'b0, 1'b0);

        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            apply(int'($urandom_range(MASK, 0)), int'($urandom_range(MASK, 0)),
                  1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule